// File: doc/BRIEF.md
# Strap-Configured Clock Output Controller

This block is the digital control core of a multi-output clock generator. Four package pins are shared: while power comes up they carry configuration straps (a three-bit frequency select and a mode bit), and once a power-up delay has elapsed they turn into clock outputs. The block captures the straps once after reset is released. It counts reference ticks to time the hand-over, and then raises the output enables for those pins.

The latched mode bit sets the role of two further shared pins. With mode 0 they are active-low run/stop inputs for the PCI and CPU clock groups. With mode 1 they drive an extra PCI clock and a buffered reference clock, and their input values are ignored. Clock stopping can also be requested through register bits. Each group's run request is synchronised into that group's clock domain, and the gate opens or closes only while the clock is low.

Top module: `clkgen_strap_ctrl`

## Requirements
- R1: On the first `clk_i` rising edge after reset is released, `strap_i` is captured. Bit 0 is S0, bit 1 is S1, bit 2 is S2 and bit 3 is MODE. `fsel_o` = `strap_i[2:0]` and `mode_o` = `strap_i[3]`. Both then hold until the next reset, whatever `strap_i` does.
- R2: `strap_oe_o` is all zeros until `DELAY_TICKS` pulses of `ref_tick_i` have been counted after reset. It then becomes all ones and stays there.
- R3: While `strap_oe_o` is zero, every gated clock output is held low.
- R4: With MODE=1, after the delay, `shared_pci_oe_o` and `shared_cpu_oe_o` are 1 and `ref_extra_o` toggles. `pci_extra_o` toggles unless `pci_stop_reg_i` is 1. The levels on both stop pins have no effect on any output.
- R5: With MODE=0, the shared output enables, `pci_extra_o` and `ref_extra_o` stay low. `pci_stop_pin_ni`=0 stops every bit of `pci_o` and `pci_stop_pin_ni`=1 lets them run. All bits of `pci_o` carry the same value.
- R6: After the delay, `pci_f_o` toggles regardless of the stop pins and the register stop bits.
- R7: `pci_stop_reg_i`=1 stops `pci_o` and `pci_extra_o` in both modes.
- R8: All bits of `cpu_o` stop together when `cpu_stop_reg_i`=1, or when MODE=0 and `cpu_stop_pin_ni`=0. Otherwise they run after the delay.
- R9: A gated output is never high while its source clock is low, so no shortened pulse appears when a gate opens or closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Control clock for strap capture and delay timer |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_tick_i | input | 1 | One-cycle reference tick counted by the delay timer |
| strap_i | input | 4 | Strap pin levels {MODE,S2,S1,S0} |
| pci_stop_pin_ni | input | 1 | Shared pin, PCI run (1) / stop (0) in mode 0 |
| cpu_stop_pin_ni | input | 1 | Shared pin, CPU run (1) / stop (0) in mode 0 |
| pci_stop_reg_i | input | 1 | Register request to stop the PCI group |
| cpu_stop_reg_i | input | 1 | Register request to stop the CPU group |
| pci_clk_i | input | 1 | Ungated PCI clock |
| cpu_clk_i | input | 1 | Ungated CPU clock |
| ref_clk_i | input | 1 | Ungated reference clock |
| strap_oe_o | output | 4 | Output enables of the four strap pins |
| shared_pci_oe_o | output | 1 | Output enable of the PCI-stop shared pin |
| shared_cpu_oe_o | output | 1 | Output enable of the CPU-stop shared pin |
| fsel_o | output | 3 | Latched frequency select |
| mode_o | output | 1 | Latched mode bit |
| pci_f_o | output | 1 | Free-running PCI clock |
| pci_o | output | N_PCI | Stoppable PCI clocks |
| pci_extra_o | output | 1 | Extra PCI clock on the shared pin (mode 1) |
| cpu_o | output | N_CPU | Stoppable CPU clocks |
| ref_extra_o | output | 1 | Reference copy on the shared pin (mode 1) |

## Verification
The bench sweeps all sixteen strap values and moves the strap pins right after capture. A design that keeps sampling would show a changed select or mode. It checks the enables just before and just after the tick count, which catches an off-by-many timer or an enable that comes too early. For each mode it drives the stop pins and register bits and counts clock edges. A design that ignores the mode, lets a pin override the free-running output, or forgets the register path would show a clock running or stopped in the wrong case. It also samples each gated clock just after its source falls, where a gate switched on the wrong phase would leave a sliver high.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  localparam int unsigned STRAP_W = 4;
  localparam int unsigned FSEL_W  = 3;

  typedef struct packed {
    logic              mode;
    logic [FSEL_W-1:0] fsel;
  } strap_t;
endpackage

// File: rtl/clkgen_strap_latch.sv
module clkgen_strap_latch
  import clkgen_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [STRAP_W-1:0] strap_i,
  output strap_t             strap_o
);
  logic   taken_q;
  strap_t strap_q;

  // one-shot capture on the first edge after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_q <= 1'b0;
      strap_q <= '0;
    end else if (!taken_q) begin
      taken_q <= 1'b1;
      strap_q <= strap_t'(strap_i);
    end
  end

  assign strap_o = strap_q;
endmodule

// File: rtl/clkgen_pwrup_timer.sv
module clkgen_pwrup_timer #(
  parameter int unsigned DELAY_TICKS = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic ready_o
);
  localparam int unsigned CW = $clog2(DELAY_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(DELAY_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else if (tick_i && !ready_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) ready_q <= 1'b1;
    end
  end

  assign ready_o = ready_q;
endmodule

// File: rtl/clkgen_clk_gate.sv
module clkgen_clk_gate #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic clk_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   en_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= run_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], run_i};
      end
    end
  endgenerate

  // enable moves on the falling edge, so it only changes while clk_i is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= sync_q[SYNC_STAGES-1];
  end

  assign clk_o = clk_i & en_q;
endmodule

// File: rtl/clkgen_strap_ctrl.sv
module clkgen_strap_ctrl
  import clkgen_pkg::*;
#(
  parameter int unsigned N_PCI       = 5,
  parameter int unsigned N_CPU       = 4,
  parameter int unsigned DELAY_TICKS = 1024,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ref_tick_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               pci_stop_pin_ni,
  input  logic               cpu_stop_pin_ni,
  input  logic               pci_stop_reg_i,
  input  logic               cpu_stop_reg_i,
  input  logic               pci_clk_i,
  input  logic               cpu_clk_i,
  input  logic               ref_clk_i,
  output logic [STRAP_W-1:0] strap_oe_o,
  output logic               shared_pci_oe_o,
  output logic               shared_cpu_oe_o,
  output logic [FSEL_W-1:0]  fsel_o,
  output logic               mode_o,
  output logic               pci_f_o,
  output logic [N_PCI-1:0]   pci_o,
  output logic               pci_extra_o,
  output logic [N_CPU-1:0]   cpu_o,
  output logic               ref_extra_o
);
  strap_t straps;
  logic   ready;
  logic   mode;
  logic   pci_stop_req, cpu_stop_req;
  logic   pci_g, cpu_g;

  clkgen_strap_latch u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .strap_i(strap_i),
    .strap_o(straps)
  );

  clkgen_pwrup_timer #(.DELAY_TICKS(DELAY_TICKS)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (ref_tick_i),
    .ready_o(ready)
  );

  assign mode = straps.mode;

  // shared pins only act as stop inputs in mode 0
  assign pci_stop_req = pci_stop_reg_i | (~mode & ~pci_stop_pin_ni);
  assign cpu_stop_req = cpu_stop_reg_i | (~mode & ~cpu_stop_pin_ni);

  clkgen_clk_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate_pcif (
    .clk_i(pci_clk_i), .rst_ni(rst_ni), .run_i(ready), .clk_o(pci_f_o)
  );
  clkgen_clk_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate_pci (
    .clk_i(pci_clk_i), .rst_ni(rst_ni), .run_i(ready & ~pci_stop_req), .clk_o(pci_g)
  );
  clkgen_clk_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate_pcix (
    .clk_i(pci_clk_i), .rst_ni(rst_ni), .run_i(ready & mode & ~pci_stop_reg_i),
    .clk_o(pci_extra_o)
  );
  clkgen_clk_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate_cpu (
    .clk_i(cpu_clk_i), .rst_ni(rst_ni), .run_i(ready & ~cpu_stop_req), .clk_o(cpu_g)
  );
  clkgen_clk_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate_refx (
    .clk_i(ref_clk_i), .rst_ni(rst_ni), .run_i(ready & mode), .clk_o(ref_extra_o)
  );

  // one gate per group keeps all members on a single enable
  for (genvar i = 0; i < N_PCI; i++) begin : g_pci_fan
    assign pci_o[i] = pci_g;
  end
  for (genvar i = 0; i < N_CPU; i++) begin : g_cpu_fan
    assign cpu_o[i] = cpu_g;
  end

  assign strap_oe_o      = {STRAP_W{ready}};
  assign shared_pci_oe_o = ready & mode;
  assign shared_cpu_oe_o = ready & mode;
  assign fsel_o          = straps.fsel;
  assign mode_o          = mode;
endmodule

// File: rtl/clkgen_strap_ctrl_chk.sv
module clkgen_strap_ctrl_chk
  import clkgen_pkg::*;
#(
  parameter int unsigned N_PCI = 5,
  parameter int unsigned N_CPU = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               pci_clk_i,
  input logic               cpu_clk_i,
  input logic [STRAP_W-1:0] strap_oe_o,
  input logic               shared_pci_oe_o,
  input logic               shared_cpu_oe_o,
  input logic [FSEL_W-1:0]  fsel_o,
  input logic               mode_o,
  input logic               pci_f_o,
  input logic [N_PCI-1:0]   pci_o,
  input logic               pci_extra_o,
  input logic [N_CPU-1:0]   cpu_o,
  input logic               ref_extra_o
);
  AST_STRAP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strap_oe_o[0] |=> ($stable(fsel_o) && $stable(mode_o))); // R1

  AST_OE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strap_oe_o[0] |=> strap_oe_o[0]); // R2

  AST_QUIET_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strap_oe_o[0] |-> (pci_o == '0 && !pci_f_o && cpu_o == '0 && !pci_extra_o && !ref_extra_o)); // R3

  AST_SHARED_OE_MODE1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shared_pci_oe_o || shared_cpu_oe_o) |-> (mode_o && strap_oe_o[0])); // R4

  AST_NO_EXTRA_MODE0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_o |-> (!pci_extra_o && !ref_extra_o)); // R5

  AST_PCI_NO_RUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pci_o[0] || pci_f_o || pci_extra_o) |-> pci_clk_i); // R9

  AST_CPU_NO_RUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_o[0] |-> cpu_clk_i); // R9
endmodule

bind clkgen_strap_ctrl clkgen_strap_ctrl_chk #(.N_PCI(N_PCI), .N_CPU(N_CPU)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .pci_clk_i      (pci_clk_i),
  .cpu_clk_i      (cpu_clk_i),
  .strap_oe_o     (strap_oe_o),
  .shared_pci_oe_o(shared_pci_oe_o),
  .shared_cpu_oe_o(shared_cpu_oe_o),
  .fsel_o         (fsel_o),
  .mode_o         (mode_o),
  .pci_f_o        (pci_f_o),
  .pci_o          (pci_o),
  .pci_extra_o    (pci_extra_o),
  .cpu_o          (cpu_o),
  .ref_extra_o    (ref_extra_o)
);

// File: tb/clkgen_strap_ctrl_tb.sv
`timescale 1ns/1ps
module clkgen_strap_ctrl_tb;
  localparam int N_PCI = 5;
  localparam int N_CPU = 4;
  localparam int DELAY = 16;
  localparam int TICK_DIV = 4;

  logic clk = 0, pci_clk = 0, cpu_clk = 0, ref_clk = 0;
  logic rst_n = 0, tick = 0;
  logic [3:0] strap = '0;
  logic pci_pin_n = 1, cpu_pin_n = 1, pci_reg = 0, cpu_reg = 0;

  logic [3:0] strap_oe;
  logic sh_pci_oe, sh_cpu_oe, mode, pci_f, pci_x, ref_x;
  logic [2:0] fsel;
  logic [N_PCI-1:0] pci;
  logic [N_CPU-1:0] cpu;

  always #10 clk = ~clk;
  always #17 pci_clk = ~pci_clk;
  always #7  cpu_clk = ~cpu_clk;
  always #35 ref_clk = ~ref_clk;

  clkgen_strap_ctrl #(.N_PCI(N_PCI), .N_CPU(N_CPU), .DELAY_TICKS(DELAY), .SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(tick), .strap_i(strap),
    .pci_stop_pin_ni(pci_pin_n), .cpu_stop_pin_ni(cpu_pin_n),
    .pci_stop_reg_i(pci_reg), .cpu_stop_reg_i(cpu_reg),
    .pci_clk_i(pci_clk), .cpu_clk_i(cpu_clk), .ref_clk_i(ref_clk),
    .strap_oe_o(strap_oe), .shared_pci_oe_o(sh_pci_oe), .shared_cpu_oe_o(sh_cpu_oe),
    .fsel_o(fsel), .mode_o(mode), .pci_f_o(pci_f), .pci_o(pci),
    .pci_extra_o(pci_x), .cpu_o(cpu), .ref_extra_o(ref_x)
  );

  int n_cmp = 0, n_bad = 0;
  int e_pcif = 0, e_pci = 0, e_pcix = 0, e_cpu = 0, e_refx = 0;
  int runts = 0, split = 0;
  bit done = 0;

  always @(posedge pci_f) e_pcif++;
  always @(posedge pci[0]) e_pci++;
  always @(posedge pci_x) e_pcix++;
  always @(posedge cpu[0]) e_cpu++;
  always @(posedge ref_x) e_refx++;
  always @(negedge pci_clk) begin #1; if (pci[0] || pci_f || pci_x) runts++; end
  always @(negedge cpu_clk) begin #1; if (cpu[0]) runts++; end
  always @(negedge ref_clk) begin #1; if (ref_x) runts++; end
  always @(posedge pci_clk) begin #2; if (pci != '0 && pci != '1) split++; end

  // tick generator, restarted by reset
  initial begin
    int tk = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) tk = 0; else tk = (tk + 1) % TICK_DIV;
      tick = rst_n && (tk == TICK_DIV - 1);
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // settle, then count rising edges of each output over a window
  task automatic window(output int rf, output int rp, output int rx, output int rc, output int rr);
    int a0, a1, a2, a3, a4;
    cyc(20);
    a0 = e_pcif; a1 = e_pci; a2 = e_pcix; a3 = e_cpu; a4 = e_refx;
    cyc(25);
    rf = (e_pcif > a0); rp = (e_pci > a1); rx = (e_pcix > a2);
    rc = (e_cpu > a3);  rr = (e_refx > a4);
  endtask

  initial begin
    int rf, rp, rx, rc, rr;
    for (int v = 0; v < 16; v++) begin
      int m;
      m = (v >> 3) & 1;
      rst_n = 0; strap = 4'(v);
      pci_pin_n = 1; cpu_pin_n = 1; pci_reg = 0; cpu_reg = 0;
      cyc(3);
      chk("R2", "oe in reset", int'(strap_oe), 0);
      rst_n = 1;
      cyc(2);
      strap = ~4'(v);
      chk("R1", "fsel", int'(fsel), v & 7);
      chk("R1", "mode", int'(mode), m);
      chk("R2", "oe early", int'(strap_oe), 0);
      window(rf, rp, rx, rc, rr);   // ~47 cycles after release
      chk("R3", "edges before ready", rf + rp + rx + rc + rr, 0);
      cyc(TICK_DIV * (DELAY - 1) - 2 - 47 - 4);
      chk("R2", "oe just before delay", int'(strap_oe), 0);
      cyc(16);
      chk("R2", "oe after delay", int'(strap_oe), 15);
      chk("R4", "shared pci oe", int'(sh_pci_oe), m);
      chk("R4", "shared cpu oe", int'(sh_cpu_oe), m);
      chk("R1", "fsel held", int'(fsel), v & 7);
      chk("R1", "mode held", int'(mode), m);

      window(rf, rp, rx, rc, rr);
      chk("R6", "pci_f run", rf, 1);
      chk("R5", "pci run", rp, 1);
      chk("R8", "cpu run", rc, 1);
      chk(m ? "R4" : "R5", "pci extra", rx, m);
      chk(m ? "R4" : "R5", "ref extra", rr, m);

      pci_pin_n = 0; cpu_pin_n = 0;
      window(rf, rp, rx, rc, rr);
      chk("R6", "pci_f with pin stop", rf, 1);
      chk(m ? "R4" : "R5", "pci under pin stop", rp, m);
      chk(m ? "R4" : "R8", "cpu under pin stop", rc, m);
      chk(m ? "R4" : "R5", "pci extra pin", rx, m);
      chk(m ? "R4" : "R5", "ref extra pin", rr, m);

      pci_pin_n = 1; cpu_pin_n = 1; pci_reg = 1;
      window(rf, rp, rx, rc, rr);
      chk("R6", "pci_f with reg stop", rf, 1);
      chk("R7", "pci reg stop", rp, 0);
      chk("R7", "pci extra reg stop", rx, 0);
      chk("R8", "cpu unaffected", rc, 1);

      pci_reg = 0; cpu_reg = 1;
      window(rf, rp, rx, rc, rr);
      chk("R8", "cpu reg stop", rc, 0);
      chk("R7", "pci restart", rp, 1);
      chk("R4", "extra restart", rx, m);
      cpu_reg = 0;
    end
    chk("R9", "runt pulses", runts, 0);
    chk("R5", "pci bits split", split, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #3ms;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule